// File: doc/BRIEF.md
# Write Completion Status Reporter

This block sits on the read path of a byte-writable nonvolatile memory. While the internal programming cycle runs, a host cannot read the array. Instead it reads status from the data bus. The block signals completion in two ways at the same time. The top data bit reports the complement of the last written top bit, but only for the last written address. The next bit flips after every finished read. Once programming ends, reads pass the array data through unchanged. At that point the top bit again shows the true stored value, and the flipping bit stops.

The block also records each accepted write. It takes the address at the start of the write strobe and the data at its end. It tells the write controller when a new write may be taken. That happens only once busy is low and a settle delay has run out. Every bus strobe is active-low and is sampled on the system clock. A read cycle is chip select and output enable both low with write enable high. A write cycle is chip select and write enable both low with output enable high.

Top module: `wr_status_reporter`

## Requirements
- R1: `busDrive` is 1 exactly while a read cycle is present on the strobes; whenever `busDrive` is 0, `busData` is 0x00.
- R2: A read while `busy` is 0 returns `arrayData` unchanged on `busData`.
- R3: A read while `busy` is 1 returns bit 7 equal to the inverse of bit 7 of the last captured write data when `addr` equals the captured address, and bit 7 equal to 0 for any other address.
- R4: During a read while `busy` is 1, bits 5 to 0 of `busData` are 0.
- R5: During a read while `busy` is 1, bit 6 shows a toggle flag. The flag inverts on the clock edge that sees the read cycle end while `busy` is 1. It is cleared to 0 on the edge that sees `busy` rise.
- R6: After `busy` falls, reads return `arrayData` again, including at the last written address.
- R7: For an accepted write, the captured address is `addr` at the first clock edge that sees the write cycle. The captured data is `wrData` at the first edge that sees the write cycle end.
- R8: `writeOk` is 0 while `busy` is 1, and it rises on the SETTLE_CYCLES+1-th clock edge after `busy` falls. A write cycle that begins while `writeOk` is 0 leaves the captured address and data unchanged.
- R9: After reset, `writeOk` is 1, the toggle flag is 0, and the captured address and data are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busy | input | 1 | Programming cycle in progress, from the write controller |
| selN | input | 1 | Chip select, active low |
| outEnN | input | 1 | Output enable, active low |
| wrEnN | input | 1 | Write enable, active low |
| addr | input | ADDR_W | Bus address |
| wrData | input | 8 | Data presented during a write cycle |
| arrayData | input | 8 | Array read data for the current address |
| busData | output | 8 | Read data toward the bus |
| busDrive | output | 1 | Tristate enable for `busData` |
| writeOk | output | 1 | A new write may be accepted |

## Verification
Polling reads are issued at the written address and at the other address present during the same write strobe. This distinguishes a capture taken at the strobe start from one taken at its end. Repeated busy reads give the alternating pattern on bit 6, while an array value of all ones shows that no array data leaks through. A write attempted during the settle window, followed by a new busy period, shows whether the ignored write changed the polling bit. The same busy period also shows that the toggle restarts from zero. Strobe combinations with write enable asserted show that the bus is not driven.

// File: rtl/wr_status_pkg.sv
package wr_status_pkg;
  // Strobes derived by the control module and consumed by the datapath.
  typedef struct packed {
    logic readNow;     // read cycle present this cycle
    logic readEnd;     // read cycle ended at this edge
    logic writeStart;  // accepted write cycle began
    logic writeEnd;    // accepted write cycle ended
    logic busyRise;    // programming just began
  } busStrobes_t;
endpackage

// File: rtl/wr_status_ctrl.sv
module wr_status_ctrl
  import wr_status_pkg::*;
#(
  parameter int SETTLE_CYCLES = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        busy,
  input  logic        selN,
  input  logic        outEnN,
  input  logic        wrEnN,
  output busStrobes_t strb,
  output logic        writeOk
);
  localparam int CNT_W = $clog2(SETTLE_CYCLES + 1);

  logic readNow, writeNow;
  logic readPrev, writePrev, busyPrev, armed;
  logic [CNT_W-1:0] settleCnt;

  assign readNow  = !selN && !outEnN && wrEnN;
  assign writeNow = !selN && !wrEnN && outEnN;

  assign writeOk = !busy && !busyPrev && (settleCnt == '0);

  always_comb begin
    strb            = '0;
    strb.readNow    = readNow;
    strb.readEnd    = readPrev && !readNow;
    strb.writeStart = writeNow && !writePrev && writeOk;
    strb.writeEnd   = writePrev && !writeNow && armed;
    strb.busyRise   = busy && !busyPrev;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      readPrev  <= 1'b0;
      writePrev <= 1'b0;
      busyPrev  <= 1'b0;
      armed     <= 1'b0;
      settleCnt <= '0;
    end else begin
      readPrev  <= readNow;
      writePrev <= writeNow;
      busyPrev  <= busy;
      if (strb.writeStart)
        armed <= 1'b1;
      else if (writePrev && !writeNow)
        armed <= 1'b0;
      if (busyPrev && !busy)
        settleCnt <= CNT_W'(SETTLE_CYCLES);
      else if (settleCnt != '0)
        settleCnt <= settleCnt - CNT_W'(1);
    end
  end

  // R8: no write acceptance while programming or right after it ends
  assert_busy_blocks_R8: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !writeOk);
  assert_settle_start_R8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |=> !writeOk);
endmodule

// File: rtl/wr_status_dp.sv
module wr_status_dp
  import wr_status_pkg::*;
#(
  parameter int ADDR_W = 15
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busy,
  input  busStrobes_t       strb,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wrData,
  input  logic [7:0]        arrayData,
  output logic [7:0]        busData,
  output logic              busDrive
);
  logic [ADDR_W-1:0] lastAddrQ;
  logic [7:0]        lastDataQ;
  logic              toggleQ;
  logic              addrHit;

  assign addrHit  = (addr == lastAddrQ);
  assign busDrive = strb.readNow;

  always_comb begin
    if (!strb.readNow)
      busData = 8'h00;
    else if (busy)
      busData = {addrHit ? ~lastDataQ[7] : 1'b0, toggleQ, 6'b000000};
    else
      busData = arrayData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lastAddrQ <= '0;
      lastDataQ <= '0;
      toggleQ   <= 1'b0;
    end else begin
      if (strb.writeStart) lastAddrQ <= addr;
      if (strb.writeEnd)   lastDataQ <= wrData;
      if (strb.busyRise)
        toggleQ <= 1'b0;
      else if (strb.readEnd && busy)
        toggleQ <= ~toggleQ;
    end
  end

  // R7: data captured at the end of an accepted write
  assert_capture_data_R7: assert property (@(posedge clk) disable iff (!rstN)
    strb.writeEnd |=> (lastDataQ == $past(wrData)));
  // R5: each finished busy read flips the toggle flag
  assert_toggle_flip_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strb.readEnd && busy && !strb.busyRise) |=> (toggleQ != $past(toggleQ)));
endmodule

// File: rtl/wr_status_reporter.sv
module wr_status_reporter
  import wr_status_pkg::*;
#(
  parameter int ADDR_W        = 15,
  parameter int SETTLE_CYCLES = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busy,
  input  logic              selN,
  input  logic              outEnN,
  input  logic              wrEnN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wrData,
  input  logic [7:0]        arrayData,
  output logic [7:0]        busData,
  output logic              busDrive,
  output logic              writeOk
);
  busStrobes_t strb;

  wr_status_ctrl #(.SETTLE_CYCLES(SETTLE_CYCLES)) uCtrl (
    .clk(clk), .rstN(rstN), .busy(busy), .selN(selN), .outEnN(outEnN),
    .wrEnN(wrEnN), .strb(strb), .writeOk(writeOk)
  );

  wr_status_dp #(.ADDR_W(ADDR_W)) uDp (
    .clk(clk), .rstN(rstN), .busy(busy), .strb(strb), .addr(addr),
    .wrData(wrData), .arrayData(arrayData), .busData(busData),
    .busDrive(busDrive)
  );

  // R1: an undriven bus carries zero
  assert_quiet_bus_R1: assert property (@(posedge clk) disable iff (!rstN)
    !busDrive |-> (busData == 8'h00));
  // R4: reserved status bits stay low during busy reads
  assert_reserved_low_R4: assert property (@(posedge clk) disable iff (!rstN)
    (busDrive && busy) |-> (busData[5:0] == 6'b0));
endmodule

// File: tb/sim_wr_status_reporter.sv
`timescale 1ns/1ps
module sim_wr_status_reporter;
  localparam int AW = 15;
  localparam int SC = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busy = 1'b0, selN = 1'b1, outEnN = 1'b1, wrEnN = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [7:0] wrData = 8'h00, arrayData = 8'h00;
  logic [7:0] busData;
  logic busDrive, writeOk;
  int vectors = 0, miscompares = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  wr_status_reporter #(.ADDR_W(AW), .SETTLE_CYCLES(SC)) u0 (
    .clk(clk), .rstN(rstN), .busy(busy), .selN(selN), .outEnN(outEnN),
    .wrEnN(wrEnN), .addr(addr), .wrData(wrData), .arrayData(arrayData),
    .busData(busData), .busDrive(busDrive), .writeOk(writeOk)
  );

  task automatic check(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic busRead(input logic [AW-1:0] a, input logic [7:0] arr,
                         output logic [7:0] d);
    @(negedge clk);
    addr = a; arrayData = arr; selN = 0; outEnN = 0; wrEnN = 1;
    @(posedge clk); #2;
    d = busData;
    check("R1 drive during read", busDrive, 1);
    @(negedge clk);
    selN = 1; outEnN = 1;
    @(posedge clk); #1;
  endtask

  task automatic busWrite(input logic [AW-1:0] a0, input logic [AW-1:0] a1,
                          input logic [7:0] d);
    @(negedge clk);
    addr = a0; wrData = 8'h5A; selN = 0; wrEnN = 0; outEnN = 1;
    @(posedge clk);
    @(negedge clk);
    addr = a1; wrData = d;
    @(posedge clk);
    @(negedge clk);
    selN = 1; wrEnN = 1;
    @(posedge clk); #1;
  endtask

  task automatic setBusy(input logic v);
    @(negedge clk); busy = v;
    @(posedge clk); #1;
  endtask

  task automatic testReset();
    logic [7:0] d;
    check("R9 writeOk after reset", writeOk, 1);
    check("R1 no drive after reset", busDrive, 0);
    check("R1 bus zero when idle", busData, 0);
    setBusy(1);
    busRead('0, 8'hFF, d);
    check("R9 R3 R5 reset capture and toggle", d, 8'h80);
    setBusy(0);
    repeat (SC + 2) @(posedge clk);
  endtask

  task automatic testStrobes();
    @(negedge clk);
    selN = 0; outEnN = 0; wrEnN = 0; #1;
    check("R1 no drive with write enable", busDrive, 0);
    check("R1 bus zero with write enable", busData, 0);
    selN = 1; wrEnN = 1; #1;
    check("R1 no drive without select", busDrive, 0);
    outEnN = 1;
  endtask

  task automatic testIdleRead();
    logic [7:0] d;
    busRead(15'h0040, 8'hA5, d);
    check("R2 idle passthrough A5", d, 8'hA5);
    busRead(15'h0041, 8'h3C, d);
    check("R2 idle passthrough 3C", d, 8'h3C);
  endtask

  task automatic testPolling();
    logic [7:0] d;
    busWrite(15'h0123, 15'h0456, 8'h3C);
    setBusy(1);
    busRead(15'h0123, 8'hFF, d);
    check("R3 R4 R5 first busy read", d, 8'h80);
    busRead(15'h0123, 8'hFF, d);
    check("R5 toggle flipped", d, 8'hC0);
    busRead(15'h0456, 8'hFF, d);
    check("R7 address taken at strobe start", d, 8'h00);
    busRead(15'h0456, 8'hFF, d);
    check("R3 R4 other address", d, 8'h40);
    setBusy(0);
    busRead(15'h0123, 8'h3C, d);
    check("R6 true data after busy", d, 8'h3C);
  endtask

  task automatic testSettle();
    int n = 0;
    setBusy(1);
    check("R8 writeOk low while busy", writeOk, 0);
    @(negedge clk); busy = 0;
    for (int i = 0; i < SC + 10; i++) begin
      @(posedge clk); #1;
      n++;
      if (writeOk) break;
    end
    check("R8 settle length", n, SC + 1);
  endtask

  task automatic testIgnoredWrite();
    logic [7:0] d;
    setBusy(1);
    @(negedge clk); busy = 0;
    busWrite(15'h0123, 15'h0123, 8'h80);
    repeat (SC + 2) @(posedge clk);
    setBusy(1);
    busRead(15'h0123, 8'h00, d);
    check("R8 R5 ignored write and toggle cleared", d, 8'h80);
    setBusy(0);
    repeat (SC + 2) @(posedge clk);
    busWrite(15'h00AA, 15'h00AA, 8'h80);
    setBusy(1);
    busRead(15'h00AA, 8'h00, d);
    check("R3 R7 new capture bit7 set", d, 8'h00);
    busRead(15'h0123, 8'h00, d);
    check("R3 previous address no longer hits", d, 8'h40);
    setBusy(0);
  endtask

  initial begin
    #20000;
    if (!finished) begin
      vectors++; miscompares++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(posedge clk); #1;
    testReset();
    testStrobes();
    testIdleRead();
    testPolling();
    testSettle();
    testIgnoredWrite();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule